// File: doc/BRIEF.md
# Pipelined Transmit Descriptor Engine

This block walks a chain of transmit descriptors in memory and feeds the bytes of each frame to a network MAC. It works in a pipelined way. When the last byte of frame N has gone out, the engine does not wait for the MAC to report on that frame. It fetches the next descriptor and sends frame N+1 at once. The last descriptor of frame N stays open in a one-entry pending-close slot. The engine closes it when frame N+1 has been sent, or earlier if the engine has suspended. To close it, the engine writes the status returned by the MAC and, when one was captured, the 64-bit timestamp.

Each descriptor is four 32-bit words at consecutive addresses:
- Word 0 holds control. Bit 31 is ownership. Bit 30 enables the completion interrupt. Bit 29 marks the last segment. Bit 28 marks the first segment. Bit 27 enables the timestamp.
- Word 1 holds the buffer byte count in bits 12:0.
- Word 2 holds the buffer address, which must be word-aligned.
- Word 3 holds the address of the next descriptor.

Descriptors and buffer words are read and written through a single-beat request/acknowledge port.

Frame bytes leave on a valid/ready byte stream that carries an end-of-frame flag. The MAC returns one status per frame, in frame order, on a valid/ready channel. The status carries an underflow flag, a timestamp-captured flag and a 64-bit timestamp.

The engine leaves reset suspended. Only a poll strobe starts it. It suspends again in two cases: when it fetches a descriptor it does not own, or when a returned status reports underflow. Status write-back still runs while the engine is suspended.

The engine has twelve states:
- `S_SUSP`: suspended.
- `S_RDESC`: reads descriptor words 0 to 3.
- `S_DRD`: reads one buffer word.
- `S_DTX`: hands out the bytes of that word.
- `S_SEGEND`: the buffer is finished.
- `S_CMID`: closes an intermediate descriptor.
- `S_FEND`: the frame is finished.
- `S_WAIT`: waits for the status of the pending frame.
- `S_WTS2` and `S_WTS3`: write the two timestamp words.
- `S_WST0`: writes the status word.
- `S_WBDONE`: settles the pending-close slot.

The transitions are:
- `S_SUSP` goes to `S_RDESC` on a poll. It goes to the write-back states when a status is held for the pending slot.
- `S_RDESC` goes to `S_SUSP` when word 0 is not owned.
- After word 3 is read, `S_RDESC` goes to `S_DRD`, or to `S_SEGEND` when the byte count is zero.
- `S_DRD` goes to `S_DTX`.
- `S_DTX` goes back to `S_DRD` after the fourth byte of a word, and to `S_SEGEND` after the final byte of the buffer.
- `S_SEGEND` goes to `S_CMID` for a non-last segment and to `S_FEND` for a last segment.
- `S_CMID` goes to `S_RDESC`.
- `S_FEND` goes to `S_RDESC` when the slot is free and to `S_WAIT` when it is occupied.
- `S_WAIT` goes to `S_WTS2` or `S_WST0`.
- `S_WTS2` goes to `S_WTS3`, then to `S_WST0`, then to `S_WBDONE`.
- `S_WBDONE` goes to `S_RDESC` after a normal status, and to `S_SUSP` after an underflow or after a write-back done while suspended.

Top module: `txd_pipe_dma`

## Requirements
- R1: After reset, `running`, `tx_valid`, `irq` and `mem_req` are 0 and `st_ready` is 1.
- R2: A poll starts a read of word 0 of the current descriptor. If bit 31 of that word is 0, the engine returns to suspend without moving any byte and without writing to memory.
- R3: The engine sends the bytes of each buffer in ascending address order, least significant byte of each word first. The number of bytes is word 1 bits 12:0. `tx_last` is 1 only on the final byte of a descriptor whose bit 29 is set. While `tx_ready` is low, `tx_data` and `tx_last` hold.
- R4: A descriptor with bit 29 clear is closed once its buffer has been sent. Word 0 is rewritten with bit 31 cleared, bits 30:27 kept and all other bits 0. The next descriptor comes from word 3.
- R5: After the last byte of frame N, the engine fetches and sends frame N+1 before it closes frame N. Frame N is closed only after the last byte of frame N+1.
- R6: A last descriptor is closed with word 0 set as follows: bit 31 is 0, bits 30:27 are kept, bit 1 is the timestamp-captured flag, bit 0 is the underflow flag, and all other bits are 0.
- R7: When the status reports a captured timestamp, word 2 receives timestamp bits 31:0 and word 3 receives bits 63:32. When it does not, words 2 and 3 keep their contents.
- R8: Closing a last descriptor whose bit 30 is set raises `irq` for one cycle. No other event raises `irq`.
- R9: An underflow status makes the engine suspend right after the close. It fetches nothing more until a poll, and the frame just sent remains pending.
- R10: A status that arrives while the engine is suspended is written back, and `running` stays 0 throughout.
- R11: Only a poll moves the engine out of suspend. With no poll, the memory port stays idle.
- R12: `mem_req` stays high with `mem_addr` and `mem_we` unchanged until `mem_ack`. Every access takes one request. `st_ready` falls after a status is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| poll | input | 1 | Poll strobe that leaves suspend |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC accepts the byte |
| st_valid | input | 1 | Frame status valid |
| st_underflow | input | 1 | Underflow was reported for the frame |
| st_tscap | input | 1 | A timestamp was captured |
| st_stamp | input | 64 | Timestamp |
| st_ready | output | 1 | Engine can accept a status |
| irq | output | 1 | One-cycle completion interrupt |
| running | output | 1 | 1 while the engine is in run, 0 while it is suspended |

## Verification
The bench sweeps the following cases:
- Frames of one and two segments.
- Byte counts from 1 to 8, including counts that cross a word boundary.
- A MAC ready pattern that stalls every fourth cycle.

It compares the stream, every descriptor word after closing and the exact count of memory cycles against values it computes itself. An engine that waited for status before moving on would close frame N before the first byte of frame N+1. An engine that always wrote the timestamp would overwrite the buffer or next-descriptor words of frames that did not capture one. In the underflow case, an engine that kept running would send the third frame before any poll. An engine that skipped write-back while suspended would leave the second frame's descriptor owned. A chain whose first descriptor is not owned must give two request cycles and no bytes; a design that decoded such a descriptor anyway would read the buffer.

// File: rtl/txd_pkg.sv
package txd_pkg;
    typedef enum logic [3:0] {
        S_SUSP, S_RDESC, S_DRD, S_DTX, S_SEGEND, S_CMID,
        S_FEND, S_WAIT, S_WTS2, S_WTS3, S_WST0, S_WBDONE
    } txd_state_e;

    localparam int OWN_BIT  = 31;
    localparam int CTRL_LSB = 27;
    localparam int CTRL_W   = 4;
    localparam int C_IOC    = 3;
    localparam int C_LAST   = 2;
    localparam int STAMP_W  = 64;
    localparam int WORD_W   = 32;
    localparam int LANES    = WORD_W / 8;
endpackage

// File: rtl/txd_close_slot.sv
module txd_close_slot
    import txd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [AW-1:0]     load_addr,
    input  logic [CTRL_W-1:0] load_ctrl,
    input  logic              clear,
    output logic              valid,
    output logic [AW-1:0]     addr,
    output logic [CTRL_W-1:0] ctrl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
            ctrl  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            addr  <= load_addr;
            ctrl  <= load_ctrl;
        end else if (clear) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/txd_stat_hold.sv
module txd_stat_hold
    import txd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_uf,
    input  logic               in_ts,
    input  logic [STAMP_W-1:0] in_stamp,
    input  logic               clear,
    output logic               ready,
    output logic               held,
    output logic               uf,
    output logic               ts,
    output logic [STAMP_W-1:0] stamp
);
    assign ready = !held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held  <= 1'b0;
            uf    <= 1'b0;
            ts    <= 1'b0;
            stamp <= '0;
        end else if (clear) begin
            held <= 1'b0;
        end else if (in_valid && !held) begin
            held  <= 1'b1;
            uf    <= in_uf;
            ts    <= in_ts;
            stamp <= in_stamp;
        end
    end
endmodule

// File: rtl/txd_pipe_dma.sv
module txd_pipe_dma
    import txd_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          CNT_W     = 13,
    parameter logic [31:0] RING_BASE = 32'h0000_0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               poll,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_ack,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    output logic               tx_last,
    input  logic               tx_ready,
    input  logic               st_valid,
    input  logic               st_underflow,
    input  logic               st_tscap,
    input  logic [STAMP_W-1:0] st_stamp,
    output logic               st_ready,
    output logic               irq,
    output logic               running
);
    localparam int LW = $clog2(LANES);

    txd_state_e          state;
    logic [1:0]          widx;
    logic [CTRL_W-1:0]   ctrl;
    logic [CNT_W-1:0]    cnt;
    logic [AW-1:0]       buf_ptr, next_ptr, desc_ptr;
    logic [WORD_W-1:0]   word_buf;
    logic [LW-1:0]       bidx;
    logic                from_susp, irq_q;

    logic                pend_valid, pend_load, pend_clear;
    logic [AW-1:0]       pend_addr;
    logic [CTRL_W-1:0]   pend_ctrl;
    logic                sh_held, sh_uf, sh_ts, sh_clear;
    logic [STAMP_W-1:0]  sh_stamp;

    txd_close_slot #(.AW(AW)) u_slot (
        .clk(clk), .rst_n(rst_n), .load(pend_load), .load_addr(desc_ptr),
        .load_ctrl(ctrl), .clear(pend_clear), .valid(pend_valid),
        .addr(pend_addr), .ctrl(pend_ctrl)
    );

    txd_stat_hold u_stat (
        .clk(clk), .rst_n(rst_n), .in_valid(st_valid), .in_uf(st_underflow),
        .in_ts(st_tscap), .in_stamp(st_stamp), .clear(sh_clear),
        .ready(st_ready), .held(sh_held), .uf(sh_uf), .ts(sh_ts), .stamp(sh_stamp)
    );

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_SUSP;
            widx      <= '0;
            ctrl      <= '0;
            cnt       <= '0;
            buf_ptr   <= '0;
            next_ptr  <= '0;
            desc_ptr  <= AW'(RING_BASE);
            word_buf  <= '0;
            bidx      <= '0;
            from_susp <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state)
                S_SUSP: begin
                    if (pend_valid && sh_held) begin
                        from_susp <= 1'b1;
                        state     <= sh_ts ? S_WTS2 : S_WST0;
                    end else if (poll) begin
                        widx  <= '0;
                        state <= S_RDESC;
                    end
                end
                S_RDESC: if (mem_ack) begin
                    widx <= widx + 2'd1;
                    unique case (widx)
                        2'd0: begin
                            ctrl <= mem_rdata[CTRL_LSB +: CTRL_W];
                            if (!mem_rdata[OWN_BIT]) state <= S_SUSP;
                        end
                        2'd1: cnt     <= mem_rdata[CNT_W-1:0];
                        2'd2: buf_ptr <= mem_rdata[AW-1:0];
                        default: begin
                            next_ptr <= mem_rdata[AW-1:0];
                            state    <= (cnt == '0) ? S_SEGEND : S_DRD;
                        end
                    endcase
                end
                S_DRD: if (mem_ack) begin
                    word_buf <= mem_rdata;
                    bidx     <= '0;
                    state    <= S_DTX;
                end
                S_DTX: if (tx_ready) begin
                    cnt  <= cnt - CNT_W'(1);
                    bidx <= bidx + LW'(1);
                    if (cnt == CNT_W'(1)) begin
                        state <= S_SEGEND;
                    end else if (bidx == LW'(LANES - 1)) begin
                        buf_ptr <= buf_ptr + AW'(LANES);
                        state   <= S_DRD;
                    end
                end
                S_SEGEND: state <= ctrl[C_LAST] ? S_FEND : S_CMID;
                S_CMID: if (mem_ack) begin
                    desc_ptr <= next_ptr;
                    widx     <= '0;
                    state    <= S_RDESC;
                end
                S_FEND: begin
                    if (pend_valid) begin
                        state <= S_WAIT;
                    end else begin
                        desc_ptr <= next_ptr;
                        widx     <= '0;
                        state    <= S_RDESC;
                    end
                end
                S_WAIT: if (sh_held) state <= sh_ts ? S_WTS2 : S_WST0;
                S_WTS2: if (mem_ack) state <= S_WTS3;
                S_WTS3: if (mem_ack) state <= S_WST0;
                S_WST0: if (mem_ack) begin
                    irq_q <= pend_ctrl[C_IOC];
                    state <= S_WBDONE;
                end
                S_WBDONE: begin
                    if (from_susp) begin
                        from_susp <= 1'b0;
                        state     <= S_SUSP;
                    end else begin
                        desc_ptr <= next_ptr;
                        widx     <= '0;
                        state    <= sh_uf ? S_SUSP : S_RDESC;
                    end
                end
                default: state <= S_SUSP;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        tx_valid   = 1'b0;
        tx_last    = 1'b0;
        tx_data    = word_buf[8*bidx +: 8];
        pend_load  = 1'b0;
        pend_clear = 1'b0;
        sh_clear   = 1'b0;
        unique case (state)
            S_RDESC: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr + AW'({widx, 2'b00});
            end
            S_DRD: begin
                mem_req  = 1'b1;
                mem_addr = buf_ptr;
            end
            S_DTX: begin
                tx_valid = 1'b1;
                tx_last  = ctrl[C_LAST] && (cnt == CNT_W'(1));
            end
            S_CMID: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_ptr;
                mem_wdata = {1'b0, ctrl, 27'b0};
            end
            S_FEND: pend_load = !pend_valid;
            S_WTS2: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pend_addr + AW'(8);
                mem_wdata = sh_stamp[31:0];
            end
            S_WTS3: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pend_addr + AW'(12);
                mem_wdata = sh_stamp[63:32];
            end
            S_WST0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pend_addr;
                mem_wdata = {1'b0, pend_ctrl, 25'b0, sh_ts, sh_uf};
            end
            S_WBDONE: begin
                pend_clear = 1'b1;
                pend_load  = !from_susp;
                sh_clear   = 1'b1;
            end
            default: ;
        endcase
        irq     = irq_q;
        running = (state != S_SUSP) && !from_susp;
    end

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    // R12
    st_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready |=> !st_ready);
    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_req && mem_we && mem_ack));
    // R11
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(poll));
    // R10
    susp_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        from_susp |-> !running && !tx_valid);
endmodule

// File: tb/txd_pipe_dma_tb.sv
module txd_pipe_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last, tx_ready;
    logic        st_valid = 1'b0, st_underflow = 1'b0, st_tscap = 1'b0;
    logic [63:0] st_stamp = '0;
    logic        st_ready, irq, running;

    always #5 clk = ~clk;

    txd_pipe_dma u_dut (
        .clk(clk), .rst_n(rst_n), .poll(poll),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .st_valid(st_valid), .st_underflow(st_underflow), .st_tscap(st_tscap),
        .st_stamp(st_stamp), .st_ready(st_ready), .irq(irq), .running(running)
    );

    logic [31:0] mem [0:1023];
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) mem_rdata <= mem[mem_addr[11:2]];
            if (mem_req && mem_ack && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        end
    end

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;
    int rx_n, frames_done, irq_n, req_n, st_sent;
    logic [7:0] rx [0:1023];
    int fb_cyc [0:15];
    int lb_cyc [0:15];
    int close_cyc [0:15];
    bit close_run [0:15];
    bit new_f;

    bit       d_own   [0:15];
    bit [3:0] d_ctrl  [0:15];
    int       d_cnt   [0:15];
    int       d_frame [0:15];
    int       nd;
    bit       f_uf [0:15];
    bit       f_ts [0:15];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction
    function automatic int daddr(int i); return 256 + 16 * i; endfunction
    function automatic int baddr(int i); return 2048 + 64 * i; endfunction
    function automatic logic [63:0] stamp_of(int k);
        return {32'hA5A5_0000 + 32'(k), 32'h3C3C_0000 + 32'(k)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        rx_n = 0; frames_done = 0; irq_n = 0; req_n = 0; st_sent = 0; new_f = 1;
        for (int i = 0; i < 16; i++) begin
            fb_cyc[i] = 0; lb_cyc[i] = 0; close_cyc[i] = 0; close_run[i] = 0;
        end
    endtask

    // MAC side: ready pattern and monitors
    initial begin
        tx_ready = 1'b1;
        forever begin
            @(negedge clk);
            tx_ready = (cyc % 4) != 3;
            if (rst_n) begin
                if (tx_valid && tx_ready) begin
                    rx[rx_n] = tx_data;
                    rx_n++;
                    if (new_f) begin fb_cyc[frames_done] = cyc; new_f = 0; end
                    if (tx_last) begin
                        lb_cyc[frames_done] = cyc;
                        frames_done++;
                        new_f = 1;
                    end
                end
                if (irq) irq_n++;
                if (mem_req) req_n++;
                if (mem_req && mem_ack && mem_we && mem_addr[3:0] == 4'h0
                    && mem_addr >= 32'h100 && mem_addr < 32'h200) begin
                    close_cyc[(mem_addr - 32'h100) >> 4] = cyc;
                    close_run[(mem_addr - 32'h100) >> 4] = running;
                end
            end
        end
    end

    // status return channel
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && frames_done > st_sent) begin
                repeat (20) @(negedge clk);
                while (!st_ready) @(negedge clk);
                st_valid = 1'b1;
                st_underflow = f_uf[st_sent];
                st_tscap = f_ts[st_sent];
                st_stamp = stamp_of(st_sent);
                @(negedge clk);
                st_valid = 1'b0;
                st_sent++;
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        poll = 1'b0;
        repeat (3) @(negedge clk);
        clear_obs();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic add_desc(input bit own, input bit [3:0] c, input int n, input int fr);
        d_own[nd] = own; d_ctrl[nd] = c; d_cnt[nd] = n; d_frame[nd] = fr;
        nd++;
    endtask

    task automatic load_mem();
        for (int w = 0; w < 1024; w++)
            mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        for (int i = 0; i < nd; i++) begin
            mem[daddr(i)/4]     = {d_own[i], d_ctrl[i], 27'b0};
            mem[daddr(i)/4 + 1] = 32'(d_cnt[i]);
            mem[daddr(i)/4 + 2] = 32'(baddr(i));
            mem[daddr(i)/4 + 3] = 32'(daddr(i + 1));
        end
    endtask

    task automatic do_poll();
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
    endtask

    task automatic wait_close(input int i);
        int n = 0;
        while (close_cyc[i] == 0 && n < 5000) begin @(negedge clk); n++; end
        repeat (5) @(negedge clk);
    endtask

    // expected stream of descriptors 0..upto-1 (R3)
    task automatic chk_stream(input int upto, input string req);
        int k = 0, miss = 0, first = -1;
        logic [7:0] ev = 0, av = 0;
        for (int i = 0; i < upto; i++)
            for (int j = 0; j < d_cnt[i]; j++) begin
                if (k >= rx_n || rx[k] !== pat(baddr(i) + j)) begin
                    if (first < 0) begin
                        first = k; ev = pat(baddr(i) + j);
                        av = (k < rx_n) ? rx[k] : 8'hxx;
                    end
                    miss++;
                end
                k++;
            end
        chk(miss == 0 && rx_n == k, req, 64'(av), 64'(ev));
        chk(rx_n == k, {req, " byte count"}, 64'(rx_n), 64'(k));
    endtask

    // closed descriptor words (R4, R6, R7)
    task automatic chk_desc(input int i);
        logic [31:0] e0, e2, e3;
        int fr = d_frame[i];
        bit lst = d_ctrl[i][2];
        if (!lst) e0 = {1'b0, d_ctrl[i], 27'b0};
        else e0 = {1'b0, d_ctrl[i], 25'b0, f_ts[fr], f_uf[fr]};
        e2 = (lst && f_ts[fr]) ? stamp_of(fr)[31:0]  : 32'(baddr(i));
        e3 = (lst && f_ts[fr]) ? stamp_of(fr)[63:32] : 32'(daddr(i + 1));
        chk(mem[daddr(i)/4] == e0, lst ? "R6 close word0" : "R4 mid close word0",
            64'(mem[daddr(i)/4]), 64'(e0));
        chk(mem[daddr(i)/4 + 2] == e2 && mem[daddr(i)/4 + 3] == e3, "R7 words2/3",
            {mem[daddr(i)/4 + 3], mem[daddr(i)/4 + 2]}, {e3, e2});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // ---------- scenario 1: pipelined sweep ----------
        clear_obs();
        nd = 0;
        add_desc(1, 4'b1111, 1, 0);
        add_desc(1, 4'b0010, 3, 1);
        add_desc(1, 4'b0100, 5, 1);
        add_desc(1, 4'b0111, 4, 2);
        add_desc(1, 4'b0010, 7, 3);
        add_desc(1, 4'b0100, 2, 3);
        add_desc(1, 4'b1111, 8, 4);
        add_desc(0, 4'b0000, 4, 5);
        for (int k = 0; k < 16; k++) begin f_uf[k] = 0; f_ts[k] = 0; end
        f_ts[0] = 1; f_ts[2] = 1; f_ts[4] = 1;
        load_mem();
        do_reset();
        // R1 reset state
        chk(!running && !tx_valid && !irq && !mem_req && st_ready, "R1 reset outputs",
            {59'b0, running, tx_valid, irq, mem_req, st_ready}, 64'h1);
        repeat (30) @(negedge clk);
        // R11 no activity without poll
        chk(req_n == 0 && !running, "R11 idle without poll", 64'(req_n), 0);
        do_poll();
        wait_close(6);
        repeat (20) @(negedge clk);
        chk_stream(7, "R3 stream sweep");
        chk(frames_done == 5, "R3 tx_last count", 64'(frames_done), 5);
        for (int i = 0; i < 7; i++) chk_desc(i);
        // R5 pipelining: frame1 starts before frame0 closes, frame0 closes after frame1 ends
        chk(fb_cyc[1] < close_cyc[0], "R5 next frame before close", 64'(fb_cyc[1]), 64'(close_cyc[0]));
        chk(close_cyc[0] > lb_cyc[1], "R5 close after next frame", 64'(close_cyc[0]), 64'(lb_cyc[1]));
        chk(close_cyc[3] > lb_cyc[3], "R5 frame2 close deferred", 64'(close_cyc[3]), 64'(lb_cyc[3]));
        chk(irq_n == 2, "R8 irq count", 64'(irq_n), 2);
        chk(!close_run[6] && !running, "R10 close in suspend", 64'(close_run[6]), 0);
        // R12: 52 accesses of two cycles each
        chk(req_n == 104, "R12 request cycles", 64'(req_n), 104);
        chk(mem[daddr(7)/4][31] == 1'b0 && mem[daddr(7)/4 + 2] == 32'(baddr(7)),
            "R2 unowned untouched", 64'(mem[daddr(7)/4 + 2]), 64'(baddr(7)));

        // ---------- scenario 2: underflow ----------
        clear_obs();
        nd = 0;
        add_desc(1, 4'b1110, 6, 0);
        add_desc(1, 4'b0110, 5, 1);
        add_desc(1, 4'b1110, 3, 2);
        add_desc(0, 4'b0000, 4, 3);
        for (int k = 0; k < 16; k++) begin f_uf[k] = 0; f_ts[k] = 0; end
        f_uf[0] = 1;
        load_mem();
        do_reset();
        chk(!running && !mem_req && st_ready, "R1 reset outputs again", 64'(running), 0);
        do_poll();
        wait_close(1);
        repeat (100) @(negedge clk);
        chk(frames_done == 2 && !running, "R9 suspend on underflow", 64'(frames_done), 2);
        chk(mem[daddr(2)/4] == {1'b1, 4'b1110, 27'b0}, "R9 third frame untouched",
            64'(mem[daddr(2)/4]), 64'({1'b1, 4'b1110, 27'b0}));
        chk(close_cyc[1] > close_cyc[0] && !close_run[1], "R10 pending written in suspend",
            64'(close_run[1]), 0);
        chk_desc(0);
        chk_desc(1);
        do_poll();
        wait_close(2);
        repeat (20) @(negedge clk);
        chk(frames_done == 3, "R11 resume on poll", 64'(frames_done), 3);
        chk_stream(3, "R3 stream underflow case");
        chk_desc(2);
        chk(irq_n == 2, "R8 irq with ioc", 64'(irq_n), 2);

        // ---------- scenario 3: unowned head ----------
        clear_obs();
        nd = 0;
        add_desc(0, 4'b1111, 4, 0);
        load_mem();
        do_reset();
        repeat (20) @(negedge clk);
        chk(req_n == 0, "R11 no poll no access", 64'(req_n), 0);
        do_poll();
        repeat (40) @(negedge clk);
        chk(rx_n == 0 && !running, "R2 unowned no transfer", 64'(rx_n), 0);
        chk(req_n == 2, "R2 single word0 read", 64'(req_n), 2);
        chk(mem[daddr(0)/4] == {1'b0, 4'b1111, 27'b0}, "R2 word0 unchanged",
            64'(mem[daddr(0)/4]), 64'({1'b0, 4'b1111, 27'b0}));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule